// File: doc/BRIEF.md
# Rectangular Pitch-Linear Copy Engine

This block moves data between two regions of memory once software has programmed it through a small array of 32-bit command registers. Each command carries a register index and a value. The value is stored at that index. A write to the launch index also starts a job, and the value written there selects what the job does.

In rectangle mode, the engine copies a fixed number of bytes on each line, for a set number of lines. The source and destination each have their own line pitch. In single-line mode, the engine copies one line. If the fill format selects the constant source, it instead writes a run of 32-bit constant words.

The engine uses a single memory port with a request/grant handshake and read data that returns later. It reports busy, a one-cycle done pulse, an unsupported flag that comes with done, and a sticky error for command indices outside the register array. Tiled layouts in rectangle mode, interrupt kinds and pipelined transfers are rejected as unsupported.

Top module: `pcopy_engine`

## Requirements
- R1: A command write stores its value at the given index, and the stored values program the next job. Only a write to the launch index (8) starts a job. Writes to any other valid index leave busy_o low.
- R2: A command with index at or above NUM_REGS (16) has no effect on the registers and does not start a job. It sets idx_err_o, which stays high until reset.
- R3: In rectangle mode (launch bit0 = 1), line n reads bytes from src_base + n*src_pitch + k and writes each byte to dst_base + n*dst_pitch + k, for k below line_len (index 4) and n below line_cnt (index 5). Each access is one byte wide (mem_wide_o = 0). Register indices: src_base 0, dst_base 1, src_pitch 2, dst_pitch 3.
- R4: In single-line mode (bit0 = 0) without constant fill, exactly line_len bytes are copied from src_base to dst_base. Line count and pitches are ignored.
- R5: In single-line mode with remap enable (bit3) and a fill format (index 7) selector field bits[2:0] = 4, line_len 32-bit writes (mem_wide_o = 1) of the fill value (index 6) go to dst_base + 4*k. Each word is stored little-endian.
- R6: A constant fill whose component-size field (index 7 bits[5:4]) is not 3 is rejected: it raises unsup_o with done_o and makes no memory access.
- R7: Rectangle mode with either side tiled (bit1 source, bit2 destination) is rejected as unsupported, with no memory access.
- R8: A nonzero interrupt kind (bits[5:4]) or the pipelined bit (bit6) is rejected as unsupported, with no memory access.
- R9: A job with line_len = 0, or with line_cnt = 0 in rectangle mode, finishes with done_o in the cycle after launch. It makes no memory access and unsup_o stays low.
- R10: busy_o rises in the cycle after an accepted launch. done_o pulses for one cycle after the final write grant, and busy_o drops in the next cycle. A launch write while busy starts no second job.
- R11: A memory request that is not granted keeps its address, direction and write data unchanged until granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_idx_i | input | IDX_W | Register index of the command |
| cmd_data_i | input | 32 | Command value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_wide_o | output | 1 | 1 = 32-bit access, 0 = byte access |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 32 | Write data (byte access uses bits 7:0) |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data byte |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle job completion pulse |
| unsup_o | output | 1 | Finished job was rejected (valid with done_o) |
| idx_err_o | output | 1 | Sticky out-of-range index error |

## Verification
A wrong walker counter or line base shows up as a misplaced byte or a wrong write count. This is visible in the memory image as soon as the job finishes, and usually at the first line turn. A state machine stuck outside idle keeps busy_o high, and the bench's per-job timeout reports it within a few thousand cycles. A misdecoded launch word appears at once as traffic when none is expected, or as a missing unsup_o on the done cycle. Stalled grants in the bench check that a held request stays unchanged.

// File: rtl/pcopy_pkg.sv
package pcopy_pkg;
  localparam int unsigned IDX_SRC   = 0;
  localparam int unsigned IDX_DST   = 1;
  localparam int unsigned IDX_SPIT  = 2;
  localparam int unsigned IDX_DPIT  = 3;
  localparam int unsigned IDX_LEN   = 4;
  localparam int unsigned IDX_CNT   = 5;
  localparam int unsigned IDX_FILL  = 6;
  localparam int unsigned IDX_FMT   = 7;
  localparam logic [2:0]  SEL_CONST = 3'd4;
  localparam logic [1:0]  COMP_4B   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RWAIT, ST_WR, ST_FILL, ST_FIN
  } st_e;

  typedef struct packed {
    logic       pipelined;
    logic [1:0] irq;
    logic       remap;
    logic       dst_tiled;
    logic       src_tiled;
    logic       multi;
  } launch_t;
endpackage

// File: rtl/pcopy_regs.sv
module pcopy_regs #(
  parameter int NUM_REGS   = 16,
  parameter int IDX_W      = 8,
  parameter int LAUNCH_IDX = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      regs_o [NUM_REGS],
  output logic             launch_o,
  output logic             idx_err_o
);
  logic bad_idx;
  assign bad_idx  = wr_en_i && ({1'b0, wr_idx_i} >= (IDX_W+1)'(NUM_REGS));
  assign launch_o = wr_en_i && (wr_idx_i == IDX_W'(LAUNCH_IDX));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [31:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   r_q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     r_q <= wr_data_i;
    end
    assign regs_o[g] = r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_err_o <= 1'b0;
    else if (bad_idx) idx_err_o <= 1'b1;
  end
endmodule

// File: rtl/pcopy_walk.sv
module pcopy_walk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [ADDR_W-1:0] src_pitch_i,
  input  logic [ADDR_W-1:0] dst_pitch_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] src_line_q, dst_line_q, sp_q, dp_q;
  logic [CNT_W-1:0]  len_q, cnt_q, col_q, line_q;
  logic              wide_q, end_of_line;

  assign end_of_line = (col_q == len_q - CNT_W'(1));
  assign last_o      = end_of_line && (line_q == cnt_q - CNT_W'(1));
  assign src_addr_o  = src_line_q + ADDR_W'(col_q);
  // constant fill advances by whole words
  assign dst_addr_o  = dst_line_q + (wide_q ? (ADDR_W'(col_q) << 2) : ADDR_W'(col_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_line_q <= '0; dst_line_q <= '0; sp_q <= '0; dp_q <= '0;
      len_q <= '0; cnt_q <= '0; col_q <= '0; line_q <= '0; wide_q <= 1'b0;
    end else if (start_i) begin
      src_line_q <= src_base_i;  dst_line_q <= dst_base_i;
      sp_q       <= src_pitch_i; dp_q       <= dst_pitch_i;
      len_q      <= len_i;       cnt_q      <= count_i;
      col_q      <= '0;          line_q     <= '0;
      wide_q     <= wide_i;
    end else if (step_i) begin
      if (end_of_line) begin
        col_q      <= '0;
        line_q     <= line_q + CNT_W'(1);
        src_line_q <= src_line_q + sp_q;
        dst_line_q <= dst_line_q + dp_q;
      end else begin
        col_q <= col_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pcopy_engine.sv
module pcopy_engine
  import pcopy_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_REGS   = 16,
  parameter int IDX_W      = 8,
  parameter int LAUNCH_IDX = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [31:0]       cmd_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_wide_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              unsup_o,
  output logic              idx_err_o
);
  localparam int CNT_W = 32;

  logic [31:0] regs [NUM_REGS];
  logic        launch_wr, go, fill_sel, unsup_now, empty, last, step;
  logic [CNT_W-1:0]  eff_count;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  launch_t     ctl;
  st_e         st_q;
  logic        unsup_q;
  logic [7:0]  byte_q;
  logic [31:0] fill_val_q;
  logic        lint_unused;

  pcopy_regs #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .LAUNCH_IDX(LAUNCH_IDX)) i_regs (
    .clk_i, .rst_ni,
    .wr_en_i(cmd_valid_i), .wr_idx_i(cmd_idx_i), .wr_data_i(cmd_data_i),
    .regs_o(regs), .launch_o(launch_wr), .idx_err_o
  );

  assign ctl       = launch_t'(cmd_data_i[6:0]);
  assign go        = launch_wr && (st_q == ST_IDLE);
  assign fill_sel  = !ctl.multi && ctl.remap && (regs[IDX_FMT][2:0] == SEL_CONST);
  assign unsup_now = (ctl.irq != 2'd0) || ctl.pipelined ||
                     (ctl.multi && (ctl.src_tiled || ctl.dst_tiled)) ||
                     (fill_sel && regs[IDX_FMT][5:4] != COMP_4B);
  assign eff_count = ctl.multi ? regs[IDX_CNT] : CNT_W'(1);
  assign empty     = (regs[IDX_LEN] == '0) || (eff_count == '0);
  assign step      = ((st_q == ST_WR) || (st_q == ST_FILL)) && mem_gnt_i;

  pcopy_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_walk (
    .clk_i, .rst_ni,
    .start_i(go), .step_i(step), .wide_i(fill_sel),
    .src_base_i(regs[IDX_SRC][ADDR_W-1:0]),  .dst_base_i(regs[IDX_DST][ADDR_W-1:0]),
    .src_pitch_i(regs[IDX_SPIT][ADDR_W-1:0]), .dst_pitch_i(regs[IDX_DPIT][ADDR_W-1:0]),
    .len_i(regs[IDX_LEN]), .count_i(eff_count),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; unsup_q <= 1'b0; byte_q <= '0; fill_val_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go) begin
          unsup_q    <= unsup_now;
          fill_val_q <= regs[IDX_FILL];
          if (unsup_now || empty) st_q <= ST_FIN;
          else if (fill_sel)      st_q <= ST_FILL;
          else                    st_q <= ST_RD;
        end
        ST_RD:    if (mem_gnt_i) st_q <= ST_RWAIT;
        ST_RWAIT: if (mem_rvalid_i) begin
          byte_q <= mem_rdata_i;
          st_q   <= ST_WR;
        end
        ST_WR:    if (mem_gnt_i) st_q <= last ? ST_FIN : ST_RD;
        ST_FILL:  if (mem_gnt_i && last) st_q <= ST_FIN;
        ST_FIN: begin
          st_q    <= ST_IDLE;
          unsup_q <= 1'b0;
        end
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_FILL);
  assign mem_we_o    = (st_q == ST_WR) || (st_q == ST_FILL);
  assign mem_wide_o  = (st_q == ST_FILL);
  assign mem_addr_o  = (st_q == ST_RD) ? src_addr : dst_addr;
  assign mem_wdata_o = (st_q == ST_FILL) ? fill_val_q : {24'h0, byte_q};
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign unsup_o     = (st_q == ST_FIN) && unsup_q;

  always_comb begin
    lint_unused = ^regs[IDX_FMT][31:6];
    for (int i = IDX_FMT + 1; i < NUM_REGS; i++) lint_unused = lint_unused ^ (^regs[i]);
  end
endmodule

// File: rtl/pcopy_engine_chk.sv
module pcopy_engine_chk #(
  parameter int ADDR_W     = 32,
  parameter int NUM_REGS   = 16,
  parameter int IDX_W      = 8,
  parameter int LAUNCH_IDX = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [IDX_W-1:0]  cmd_idx_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_wide_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_gnt_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              unsup_o,
  input logic              idx_err_o
);
  logic launch_hit, bad_hit;
  assign launch_hit = cmd_valid_i && (cmd_idx_i == IDX_W'(LAUNCH_IDX));
  assign bad_hit    = cmd_valid_i && ({{(32-IDX_W){1'b0}}, cmd_idx_i} >= 32'(NUM_REGS));

  p_nontrigger_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !launch_hit) |=> !busy_o);
  p_bad_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_hit |=> idx_err_o);
  p_err_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_err_o |=> idx_err_o);
  p_wide_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_wide_o) |-> mem_we_o);
  p_unsup_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> done_o);
  p_launch_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_hit && !busy_o) |=> busy_o);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  p_done_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o));
  p_hold_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                  $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

bind pcopy_engine pcopy_engine_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .LAUNCH_IDX(LAUNCH_IDX)
) i_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_idx_i, .mem_req_o, .mem_we_o, .mem_wide_o,
  .mem_addr_o, .mem_wdata_o, .mem_gnt_i, .busy_o, .done_o, .unsup_o, .idx_err_o
);

// File: tb/test_pcopy_engine.sv
module test_pcopy_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_idx = '0;
  logic [31:0] cmd_data = '0;
  logic        mem_req, mem_we, mem_wide, busy, done, unsup, idx_err;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;

  logic [7:0]  mem [1024];
  logic [7:0]  exp_mem [1024];
  int checks = 0, fails = 0;
  int wr_cnt = 0, wide_cnt = 0, done_cnt = 0, tick = 0;
  bit stall_en = 1'b0;

  pcopy_engine i_pcopy_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_idx_i(cmd_idx), .cmd_data_i(cmd_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .unsup_o(unsup), .idx_err_o(idx_err)
  );

  initial forever #4 clk = ~clk;

  // memory model: acts at falling edges
  initial begin
    bit rd_pend = 1'b0;
    logic [7:0] rd_byte = '0;
    forever begin
      @(negedge clk);
      tick++;
      mem_rvalid = rd_pend;
      mem_rdata  = rd_byte;
      rd_pend    = 1'b0;
      if (done) done_cnt++;
      if (mem_req && (!stall_en || (tick % 3 == 2))) begin
        mem_gnt = 1'b1;
        if (!mem_we) begin
          rd_pend = 1'b1;
          rd_byte = mem[mem_addr[9:0]];
        end else begin
          wr_cnt++;
          if (mem_wide) begin
            wide_cnt++;
            for (int k = 0; k < 4; k++) mem[(mem_addr[9:0] + 10'(k))] = mem_wdata[8*k +: 8];
          end else begin
            mem[mem_addr[9:0]] = mem_wdata[7:0];
          end
        end
      end else begin
        mem_gnt = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_idx = 8'(idx); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cfg(input int src, input int dst, input int sp, input int dp,
                     input int len, input int cnt);
    wr(0, src); wr(1, dst); wr(2, sp); wr(3, dp); wr(4, len); wr(5, cnt);
  endtask

  task automatic launch(input logic [31:0] ctl);
    wr(8, ctl);
    chk(busy == 1'b1, "R10", "busy one cycle after launch", busy, 1);
  endtask

  task automatic wait_done(output bit was_unsup);
    int cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, "R10", "job finished", done, 1);
    was_unsup = unsup;
    @(negedge clk);
    chk(busy == 1'b0, "R10", "busy low after done", busy, 0);
  endtask

  task automatic model_copy(input int src, input int dst, input int sp, input int dp,
                            input int len, input int cnt);
    for (int n = 0; n < cnt; n++)
      for (int b = 0; b < len; b++)
        exp_mem[(dst + n*dp + b) % 1024] = exp_mem[(src + n*sp + b) % 1024];
  endtask

  task automatic verify_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, req, "memory image mismatching bytes", bad, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && mem_req == 0, "R10", "idle after reset",
        {busy, done, mem_req}, 0);
    chk(idx_err == 0, "R2", "error clear after reset", idx_err, 0);
  endtask

  task automatic t_no_trigger();
    int w0 = wr_cnt;
    wr(5, 32'd7); wr(0, 32'h10);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1", "non-launch index starts nothing", busy, 0);
    chk(wr_cnt == w0, "R1", "no traffic", wr_cnt - w0, 0);
  endtask

  task automatic t_rect(input bit stall, input int src, input int dst, input int sp,
                        input int dp, input int len, input int cnt);
    int w0 = wr_cnt; bit u;
    stall_en = stall;
    cfg(src, dst, sp, dp, len, cnt);
    model_copy(src, dst, sp, dp, len, cnt);
    launch(32'h1);
    wait_done(u);
    chk(u == 0, "R3", "rectangle not rejected", u, 0);
    chk(wr_cnt - w0 == len*cnt, "R3", "byte write count", wr_cnt - w0, len*cnt);
    verify_mem(stall ? "R11" : "R3");
    stall_en = 1'b0;
  endtask

  task automatic t_single();
    int w0 = wr_cnt; bit u;
    cfg(32'h0A0, 32'h380, 50, 60, 13, 5);
    model_copy(32'h0A0, 32'h380, 0, 0, 13, 1);
    launch(32'h0);
    wait_done(u);
    chk(wr_cnt - w0 == 13, "R4", "single line write count", wr_cnt - w0, 13);
    verify_mem("R4");
    // remap enabled but selector not the constant: still a plain copy
    w0 = wr_cnt;
    wr(7, 32'h31);
    cfg(32'h0B0, 32'h3C0, 0, 0, 9, 2);
    model_copy(32'h0B0, 32'h3C0, 0, 0, 9, 1);
    launch(32'h8);
    wait_done(u);
    chk(wr_cnt - w0 == 9, "R4", "non-constant selector copies", wr_cnt - w0, 9);
    verify_mem("R4");
  endtask

  task automatic t_fill();
    int w0 = wr_cnt, d0 = wide_cnt; bit u;
    logic [31:0] v = 32'hA5C3_1E07;
    wr(7, 32'h34); wr(6, v);
    cfg(0, 32'h1C0, 0, 0, 6, 9);
    for (int k = 0; k < 24; k++) exp_mem[32'h1C0 + k] = v[8*(k%4) +: 8];
    launch(32'h8);
    wait_done(u);
    chk(u == 0, "R5", "fill accepted", u, 0);
    chk(wide_cnt - d0 == 6, "R5", "word write count", wide_cnt - d0, 6);
    chk(wr_cnt - w0 == 6, "R5", "total write count", wr_cnt - w0, 6);
    verify_mem("R5");
  endtask

  task automatic t_reject(input logic [31:0] fmt, input logic [31:0] ctl, input string req);
    int w0 = wr_cnt; bit u;
    wr(7, fmt);
    cfg(32'h040, 32'h240, 16, 16, 4, 2);
    launch(ctl);
    wait_done(u);
    chk(u == 1, req, "unsupported flagged", u, 1);
    chk(wr_cnt == w0, req, "no writes on reject", wr_cnt - w0, 0);
    verify_mem(req);
  endtask

  task automatic t_zero(input int len, input int cnt);
    int w0 = wr_cnt; bit u;
    cfg(32'h040, 32'h240, 8, 8, len, cnt);
    launch(32'h1);
    chk(done == 1, "R9", "done in cycle after launch", done, 1);
    wait_done(u);
    chk(u == 0, "R9", "empty job not unsupported", u, 0);
    chk(wr_cnt == w0, "R9", "no traffic on empty job", wr_cnt - w0, 0);
  endtask

  task automatic t_busy_launch();
    int w0 = wr_cnt, c0 = done_cnt; bit u;
    stall_en = 1'b1;
    cfg(32'h060, 32'h2A0, 12, 20, 8, 3);
    model_copy(32'h060, 32'h2A0, 12, 20, 8, 3);
    launch(32'h1);
    repeat (6) @(negedge clk);
    wr(1, 32'h3F0);
    wr(8, 32'h1);
    wait_done(u);
    chk(wr_cnt - w0 == 24, "R10", "launch while busy ignored", wr_cnt - w0, 24);
    repeat (6) @(negedge clk);
    chk(busy == 0, "R10", "no second job", busy, 0);
    chk(done_cnt - c0 == 1, "R10", "single done pulse", done_cnt - c0, 1);
    verify_mem("R10");
    stall_en = 1'b0;
  endtask

  task automatic t_bad_idx();
    wr(20, 32'h1);
    chk(idx_err == 1, "R2", "error set on bad index", idx_err, 1);
    chk(busy == 0, "R2", "bad index starts nothing", busy, 0);
    wr(24, 32'h1);
    wr(3, 32'h4);
    chk(idx_err == 1, "R2", "error sticky", idx_err, 1);
    chk(busy == 0, "R2", "aliased launch index ignored", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'(i*37 + 11);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_trigger();
    t_rect(1'b0, 32'h040, 32'h200, 20, 32, 10, 4);
    t_rect(1'b1, 32'h300, 32'h100, 7, 16, 5, 6);
    t_single();
    t_fill();
    t_reject(32'h14, 32'h8,  "R6");
    t_reject(32'h0,  32'h7,  "R7");
    t_reject(32'h0,  32'h3,  "R7");
    t_reject(32'h0,  32'h11, "R8");
    t_reject(32'h0,  32'h41, "R8");
    t_zero(0, 3);
    t_zero(4, 0);
    t_busy_launch();
    t_bad_idx();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule